// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Controller

This block is the digital half of a synthesizer feedback divider. It runs on the output clock of an external dual-modulus prescaler and, in every divide cycle, steers the prescaler's modulus-control line so that the VCO frequency is divided by P×B+A. Here P is the lower prescaler modulus, B is the main count and A is the swallow count. The cycle opens with the prescaler dividing by P+1 for A of its output cycles. It then divides by P for the remaining B−A cycles. On the last prescaler cycle of the divide cycle the block emits a one-cycle pulse toward the phase detector.

A and B, together with a prescaler-select bit, are written through a simple write port. A write lands in a pending set. The pending set moves into the active set only at a divide-cycle boundary, or at any time while the sequencer is idle. A write that breaks the rules B ≥ 3 and A ≤ B is refused, and an error flag is raised. A synchronous reset and a powerdown input both stop the divider. Once both are low, the divider restarts at the very next edge at the start of a fresh cycle, so its phase is fixed by the release edge.

The sequencer has three states. IDLE holds while the block is in reset or powerdown. SWALLOW drives modulus-control high. MAIN drives it low. Four transitions connect them:
- START goes from IDLE to SWALLOW, or to MAIN when A is 0, on the first edge with reset and powerdown low.
- SWALLOW_DONE goes from SWALLOW to MAIN once A prescaler cycles have elapsed.
- WRAP goes from SWALLOW or MAIN to SWALLOW or MAIN on the last cycle of B, reloading the counts.
- SLEEP goes from SWALLOW or MAIN to IDLE when powerdown is sampled high.

A parameter narrows the used swallow bits for an intermediate-frequency channel. Bits above that width are then ignored.

Top module: `psw_divider_ctrl`

## Requirements
- R1: When `rst` is sampled high, from the next cycle `mod_hi`, `div_pulse`, `cfg_err` and `psel_o` are 0. Both the pending and the active counts become A=RST_A and B=RST_B. A write presented in the same cycle is discarded.
- R2: On the first edge with `rst` and `pwr_dn` both low, a divide cycle starts. `mod_hi` is 1 for the first A prescaler cycles and 0 for the remaining B−A. `div_pulse` is 1 only in the B-th cycle. The next cycle begins immediately after, so the period is B cycles.
- R3: Counting P+1 VCO cycles for each prescaler cycle with `mod_hi`=1 and P for each with `mod_hi`=0, one divide cycle totals P×B+A. P is 64 when `psel_o`=0 and 128 when `psel_o`=1.
- R4: With A=0, `mod_hi` stays 0 for the whole cycle. With A=B, `mod_hi` stays 1 for the whole cycle, including the pulse cycle.
- R5: An accepted write changes the active A, B and select only at the next divide-cycle boundary. A write sampled on the boundary edge itself applies at the boundary after that.
- R6: A write with `wr_b` < 3, or with the used bits of `wr_a` greater than `wr_b`, leaves the pending values unchanged and sets `cfg_err` from the next cycle. The next accepted write clears `cfg_err`.
- R7: While `pwr_dn` is sampled high, `mod_hi` and `div_pulse` are 0 from the next cycle on. Writes are still accepted. On release, a fresh cycle starts at the first edge with `pwr_dn` low.
- R8: `psel_o` shows the active select bit. In IDLE the active set follows the pending set every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pre_clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_dn | input | 1 | Powerdown: stops the divider |
| wr_en | input | 1 | Write strobe for the count set |
| wr_a | input | AW | New swallow count A |
| wr_b | input | BW | New main count B |
| wr_psel | input | 1 | New prescaler select (0: lower modulus pair, 1: upper pair) |
| mod_hi | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| div_pulse | output | 1 | One-cycle pulse on the last cycle of each divide cycle |
| psel_o | output | 1 | Active prescaler select |
| cfg_err | output | 1 | Last write was refused |

## Verification
Every output is registered, so any input sampled on edge k shows its effect just after edge k. Reset, powerdown and the error flag therefore respond one cycle after they are sampled. The first `mod_hi` and cycle position follow one cycle after release. A count write shows up only after the boundary edge that follows it, which can be up to B cycles later. The bench's behavioural model advances on the same edge the design samples. It compares all four outputs on the falling edge, when the registered results are stable. The VCO total is added up on those same falling edges and checked in the pulse cycle.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SWAL = 2'd1,
        S_MAIN = 2'd2
    } seq_state_t;
endpackage

// File: rtl/psw_cfg_regs.sv
`timescale 1ns/1ps
module psw_cfg_regs #(
    parameter int AW    = 7,
    parameter int BW    = 11,
    parameter int RST_A = 2,
    parameter int RST_B = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_a,
    input  logic [BW-1:0] wr_b,
    input  logic          wr_psel,
    output logic [AW-1:0] pend_a,
    output logic [BW-1:0] pend_b,
    output logic          pend_psel,
    output logic          cfg_err
);
    localparam logic [BW-1:0] B_MIN = BW'(3);

    logic wr_ok;

    // legality: main count at least 3, swallow not above main
    always_comb begin
        wr_ok = (wr_b >= B_MIN) && (BW'(wr_a) <= wr_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_a    <= AW'(RST_A);
            pend_b    <= BW'(RST_B);
            pend_psel <= 1'b0;
            cfg_err   <= 1'b0;
        end else if (wr_en) begin
            if (wr_ok) begin
                pend_a    <= wr_a;
                pend_b    <= wr_b;
                pend_psel <= wr_psel;
                cfg_err   <= 1'b0;
            end else begin
                cfg_err   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/psw_seq_fsm.sv
`timescale 1ns/1ps
module psw_seq_fsm
    import psw_pkg::*;
#(
    parameter int AW    = 7,
    parameter int BW    = 11,
    parameter int RST_A = 2,
    parameter int RST_B = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_dn,
    input  logic [AW-1:0] pend_a,
    input  logic [BW-1:0] pend_b,
    input  logic          pend_psel,
    output seq_state_t    state,
    output logic [BW-1:0] cnt,
    output logic [AW-1:0] act_a,
    output logic [BW-1:0] act_b,
    output logic          act_psel,
    output logic          at_end
);
    seq_state_t      state_nx;
    logic [BW-1:0]   cnt_inc;
    logic            load_en;
    seq_state_t      start_st;

    always_comb begin
        cnt_inc  = cnt + 1'b1;
        at_end   = (cnt == (act_b - 1'b1));
        start_st = (pend_a != '0) ? S_SWAL : S_MAIN;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (!pwr_dn)              state_nx = start_st;   // START
            end
            S_SWAL: begin
                if (pwr_dn)               state_nx = S_IDLE;     // SLEEP
                else if (at_end)          state_nx = start_st;   // WRAP
                else if (cnt_inc == BW'(act_a))
                                          state_nx = S_MAIN;     // SWALLOW_DONE
            end
            S_MAIN: begin
                if (pwr_dn)               state_nx = S_IDLE;     // SLEEP
                else if (at_end)          state_nx = start_st;   // WRAP
            end
            default:                      state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // active set moves only at a boundary, in idle, or on sleep
    always_comb begin
        load_en = pwr_dn || (state == S_IDLE) || at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_a    <= AW'(RST_A);
            act_b    <= BW'(RST_B);
            act_psel <= 1'b0;
        end else begin
            if (load_en) begin
                act_a    <= pend_a;
                act_b    <= pend_b;
                act_psel <= pend_psel;
            end
            if (pwr_dn || state == S_IDLE || at_end) cnt <= '0;
            else                                     cnt <= cnt_inc;
        end
    end
endmodule

// File: rtl/psw_out_dec.sv
`timescale 1ns/1ps
module psw_out_dec
    import psw_pkg::*;
(
    input  seq_state_t state,
    input  logic       at_end,
    output logic       mod_hi,
    output logic       div_pulse
);
    always_comb begin
        mod_hi    = 1'b0;
        div_pulse = 1'b0;
        unique case (state)
            S_IDLE: begin
                mod_hi    = 1'b0;
                div_pulse = 1'b0;
            end
            S_SWAL: begin
                mod_hi    = 1'b1;
                div_pulse = at_end;
            end
            S_MAIN: begin
                mod_hi    = 1'b0;
                div_pulse = at_end;
            end
            default: begin
                mod_hi    = 1'b0;
                div_pulse = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/psw_divider_ctrl.sv
`timescale 1ns/1ps
module psw_divider_ctrl
    import psw_pkg::*;
#(
    parameter int AW     = 7,
    parameter int BW     = 11,
    parameter int A_USED = 7,
    parameter int RST_A  = 2,
    parameter int RST_B  = 8
) (
    input  logic          pre_clk,
    input  logic          rst,
    input  logic          pwr_dn,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_a,
    input  logic [BW-1:0] wr_b,
    input  logic          wr_psel,
    output logic          mod_hi,
    output logic          div_pulse,
    output logic          psel_o,
    output logic          cfg_err
);
    logic [AW-1:0] a_eff;
    logic [AW-1:0] pend_a;
    logic [BW-1:0] pend_b;
    logic          pend_psel;
    seq_state_t    state;
    logic [BW-1:0] cnt;
    logic [AW-1:0] act_a;
    logic [BW-1:0] act_b;
    logic          at_end;

    // narrower swallow field: upper bits are ignored
    generate
        if (A_USED < AW) begin : g_a_mask
            assign a_eff = {{(AW-A_USED){1'b0}}, wr_a[A_USED-1:0]};
        end else begin : g_a_full
            assign a_eff = wr_a;
        end
    endgenerate

    psw_cfg_regs #(.AW(AW), .BW(BW), .RST_A(RST_A), .RST_B(RST_B)) u_cfg (
        .clk       (pre_clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_a      (a_eff),
        .wr_b      (wr_b),
        .wr_psel   (wr_psel),
        .pend_a    (pend_a),
        .pend_b    (pend_b),
        .pend_psel (pend_psel),
        .cfg_err   (cfg_err)
    );

    psw_seq_fsm #(.AW(AW), .BW(BW), .RST_A(RST_A), .RST_B(RST_B)) u_seq (
        .clk       (pre_clk),
        .rst       (rst),
        .pwr_dn    (pwr_dn),
        .pend_a    (pend_a),
        .pend_b    (pend_b),
        .pend_psel (pend_psel),
        .state     (state),
        .cnt       (cnt),
        .act_a     (act_a),
        .act_b     (act_b),
        .act_psel  (psel_o),
        .at_end    (at_end)
    );

    psw_out_dec u_out (
        .state     (state),
        .at_end    (at_end),
        .mod_hi    (mod_hi),
        .div_pulse (div_pulse)
    );
endmodule

// File: rtl/psw_divider_ctrl_chk.sv
`timescale 1ns/1ps
module psw_divider_ctrl_chk
    import psw_pkg::*;
#(
    parameter int AW = 7,
    parameter int BW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          pwr_dn,
    input logic          wr_en,
    input logic [AW-1:0] a_eff,
    input logic [BW-1:0] wr_b,
    input logic          mod_hi,
    input logic          div_pulse,
    input logic          cfg_err,
    input seq_state_t    state,
    input logic [AW-1:0] act_a,
    input logic [BW-1:0] act_b
);
    // R1: reset silences the outputs
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!mod_hi && !div_pulse && !cfg_err));

    // R2: the pulse never lasts two cycles
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R2: once low inside a cycle, modulus control stays low until the wrap
    p_mod_order_r2: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && !mod_hi && !div_pulse && !pwr_dn) |=> !mod_hi);

    // R5: active counts hold still in mid-cycle
    p_active_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && !div_pulse && !pwr_dn) |=> ($stable(act_a) && $stable(act_b)));

    // R6: a refused write raises the flag
    p_err_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_b < BW'(3) || BW'(a_eff) > wr_b)) |=> cfg_err);

    // R6: active counts always legal
    p_active_legal_r6: assert property (@(posedge clk) disable iff (rst)
        (act_b >= BW'(3)) && (BW'(act_a) <= act_b));

    // R7: powerdown stops the divider
    p_pdn_idle_r7: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> (!mod_hi && !div_pulse));
endmodule

bind psw_divider_ctrl psw_divider_ctrl_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk       (pre_clk),
    .rst       (rst),
    .pwr_dn    (pwr_dn),
    .wr_en     (wr_en),
    .a_eff     (a_eff),
    .wr_b      (wr_b),
    .mod_hi    (mod_hi),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err),
    .state     (state),
    .act_a     (act_a),
    .act_b     (act_b)
);

// File: tb/psw_divider_ctrl_tb.sv
`timescale 1ns/1ps
module psw_divider_ctrl_tb;
    localparam int AW = 7;
    localparam int BW = 11;
    localparam int RA = 2;
    localparam int RB = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_dn = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_a = '0;
    logic [BW-1:0] wr_b = '0;
    logic          wr_psel = 1'b0;
    logic          mod_hi, div_pulse, psel_o, cfg_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    bit cmp_on = 0;
    string tag = "R1";

    // reference model state
    int  run = 0, pos = 0, ma = RA, mb = RB, mps = 0;
    int  pa = RA, pb = RB, pps = 0, merr = 0;
    longint vco = 0;

    always #2 clk = ~clk;   // 250 MHz

    psw_divider_ctrl #(.AW(AW), .BW(BW), .A_USED(7), .RST_A(RA), .RST_B(RB)) u_dut (
        .pre_clk(clk), .rst(rst), .pwr_dn(pwr_dn), .wr_en(wr_en),
        .wr_a(wr_a), .wr_b(wr_b), .wr_psel(wr_psel),
        .mod_hi(mod_hi), .div_pulse(div_pulse), .psel_o(psel_o), .cfg_err(cfg_err)
    );

    task automatic chk(input string t, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", t, what, act, exp, cyc);
        end
    endtask

    // behavioural model, advances on the edge the design samples
    always @(posedge clk) begin
        cyc++;
        cmp_on = 1;
        if (rst) begin
            run = 0; pos = 0; ma = RA; mb = RB; mps = 0;
            pa = RA; pb = RB; pps = 0; merr = 0;
        end else begin
            if (pwr_dn) begin
                run = 0; pos = 0; ma = pa; mb = pb; mps = pps;
            end else if (run == 0 || pos == mb - 1) begin
                run = 1; pos = 0; ma = pa; mb = pb; mps = pps;
            end else begin
                pos++;
            end
            if (wr_en) begin
                if (int'(wr_b) >= 3 && int'(wr_a) <= int'(wr_b)) begin
                    pa = wr_a; pb = wr_b; pps = wr_psel; merr = 0;
                end else begin
                    merr = 1;
                end
            end
        end
        if (cyc > 150000 && !done) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(tag, "mod_hi",    mod_hi,    (run != 0 && pos < ma) ? 1 : 0);
            chk(tag, "div_pulse", div_pulse, (run != 0 && pos == mb - 1) ? 1 : 0);
            chk(tag, "cfg_err",   cfg_err,   merr);
            chk(tag, "psel_o",    psel_o,    mps);
            if (run != 0) begin
                longint p;
                p = (mps != 0) ? 128 : 64;
                if (pos == 0) vco = 0;
                vco += mod_hi ? p + 1 : p;
                if (div_pulse) chk("R3", "vco_total", vco, p * mb + ma);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int b, input bit ps);
        @(negedge clk);
        wr_en = 1'b1; wr_a = AW'(a); wr_b = BW'(b); wr_psel = ps;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        // R1: reset state, and a write during reset is discarded
        tag = "R1";
        tick(2);
        wr_en = 1'b1; wr_a = 7'd9; wr_b = 11'd40; wr_psel = 1'b1;
        tick(1);
        wr_en = 1'b0;
        tick(1);
        chk("R1", "mod_hi_in_reset", mod_hi, 0);
        chk("R1", "psel_in_reset", psel_o, 0);
        rst = 1'b0;

        // R2: default cycle shape
        tag = "R2";
        tick(30);

        // R5/R8: mid-cycle write, effect at the boundary
        tag = "R5";
        tick(3);
        wr(5, 20, 1'b1);
        tag = "R8";
        tick(60);

        // R4: swallow zero, swallow equal to main
        tag = "R4";
        wr(0, 3, 1'b0);
        tick(40);
        wr(10, 10, 1'b1);
        tick(45);

        // R6: refused writes keep the old counts
        tag = "R6";
        wr(1, 2, 1'b0);
        tick(12);
        chk("R6", "err_after_b_low", cfg_err, 1);
        wr(11, 10, 1'b0);
        tick(25);
        wr(4, 12, 1'b0);
        tick(30);
        chk("R6", "err_cleared", cfg_err, 0);

        // R5: write sampled on the boundary edge
        tag = "R5";
        do @(negedge clk); while (!div_pulse);
        wr_en = 1'b1; wr_a = 7'd6; wr_b = 11'd9; wr_psel = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        tick(40);

        // R7: powerdown mid-cycle, write during powerdown, release
        tag = "R7";
        tick(4);
        pwr_dn = 1'b1;
        tick(3);
        wr(3, 7, 1'b0);
        tick(5);
        chk("R7", "mod_hi_pdn", mod_hi, 0);
        pwr_dn = 1'b0;
        tick(30);

        // R1: reset mid-run with a write
        tag = "R1";
        tick(3);
        rst = 1'b1; wr_en = 1'b1; wr_a = 7'd1; wr_b = 11'd5;
        tick(2);
        rst = 1'b0; wr_en = 1'b0;
        tick(20);

        // R3: extreme counts
        tag = "R3";
        wr(127, 2047, 1'b1);
        tick(4200);
        wr(0, 2047, 1'b0);
        tick(4200);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule